// File: doc/BRIEF.md
# Burst Write Engine

The engine takes one command at a time and turns it into a memory-mapped write burst. A command gives a start address, a beat count, a data source, a pause pattern and byte-enable masks for the first and last beats. While it runs the burst, the engine drives the write strobe, the write data, the byte enables, the burst count and the address. It also raises a burst-start marker on the burst's opening cycle. The slave can stall any beat by raising its wait request. While the slave stalls, the engine freezes every output and only moves on after the beat has been taken.

Write data comes from one of two sources. The first is a counter that starts from a seed the command supplies. The second is a small internal buffer, read in circular order and filled beforehand through a write port. The engine can pause on purpose between beats. It does this by dropping the write strobe for one cycle wherever the command's pause pattern holds a one. The parameter `HOLD_CMD` selects how address and burst count are presented. When it is set, they stay on the bus for the whole burst. When it is clear, they appear only on the first beat. After the final beat is accepted, a one-cycle completion pulse follows.

The control state machine has four states. `ST_IDLE` waits for a command. `ST_BEAT` presents a beat with the write strobe high. `ST_PAUSE` is a voluntary one-cycle gap. `ST_FINISH` is the completion cycle. The transitions are as follows:
- IDLE→BEAT when a command with a nonzero count is taken.
- BEAT→BEAT after an accepted non-final beat with no pause due, or while the slave stalls.
- BEAT→PAUSE after an accepted non-final beat whose pattern bit is one.
- PAUSE→BEAT always.
- BEAT→FINISH after the final beat is accepted.
- FINISH→IDLE always.

Top module: `burst_wr_engine`

## Requirements
- R1: `cmd_ready` is high only in the idle state. A command with `cmd_valid` and `cmd_ready` high and a nonzero `cmd_len` is taken at that clock edge, and in the next cycle `mm_write` is high.
- R2: A command whose `cmd_len` is 0 is ignored. No burst starts and `cmd_ready` stays high.
- R3: `mm_burst_start` is high in exactly one cycle per burst, the first cycle of the burst (with `mm_write` high), and it is low in the next cycle even if `mm_waitreq` was high.
- R4: A beat is transferred at a clock edge where `mm_write` is high and `mm_waitreq` is low. Exactly `cmd_len` beats are transferred per burst.
- R5: While `mm_write` and `mm_waitreq` are both high, `mm_write`, `mm_wdata`, `mm_be`, `mm_addr` and `mm_bcount` hold their values into the next cycle.
- R6: After the transfer of non-final beat k (counted from 0), `mm_write` is low for exactly one cycle if bit (k mod `GAP_W`) of `cmd_gap` is 1. Otherwise it stays high in the next cycle.
- R7: With `cmd_src` = 0, beat k carries `cmd_seed` + k modulo 2^`DATA_W`.
- R8: With `cmd_src` = 1, beat k carries buffer entry (k mod `BUF_DEPTH`). A cycle with `buf_wr_en` high writes `buf_wr_data` into entry `buf_wr_idx`.
- R9: Beat 0 carries `cmd_be_first` and the final beat carries `cmd_be_last`. A single-beat burst carries their bitwise AND. Every other beat enables all bytes.
- R10: With `HOLD_CMD` = 1, `mm_addr` and `mm_bcount` equal the command's address and count in every cycle of the burst, pauses included.
- R11: With `HOLD_CMD` = 0, `mm_addr` and `mm_bcount` carry the command values only until the first beat is transferred, and are zero afterwards.
- R12: `burst_done` is high for exactly the one cycle after the final beat transfer, and `cmd_ready` is high in the cycle after that.
- R13: Out of reset and whenever idle, `mm_write`, `mm_burst_start` and `burst_done` are low, and `mm_addr` and `mm_bcount` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_addr | input | ADDR_W | Burst start address |
| cmd_len | input | CNT_W | Beat count (0 is ignored) |
| cmd_src | input | 1 | 0: counter data, 1: buffer data |
| cmd_seed | input | DATA_W | Counter start value |
| cmd_gap | input | GAP_W | Pause pattern, bit per beat index mod GAP_W |
| cmd_be_first | input | DATA_W/8 | Byte enables of the first beat |
| cmd_be_last | input | DATA_W/8 | Byte enables of the last beat |
| buf_wr_en | input | 1 | Buffer write strobe |
| buf_wr_idx | input | $clog2(BUF_DEPTH) | Buffer entry to write |
| buf_wr_data | input | DATA_W | Buffer write data |
| mm_addr | output | ADDR_W | Bus address |
| mm_bcount | output | CNT_W | Bus burst count |
| mm_write | output | 1 | Write strobe |
| mm_wdata | output | DATA_W | Write data |
| mm_be | output | DATA_W/8 | Byte enables |
| mm_burst_start | output | 1 | High on the first cycle of a burst |
| mm_waitreq | input | 1 | Slave stall |
| burst_done | output | 1 | One-cycle completion pulse |

## Verification
The bench stalls the first cycle of a burst, to catch a burst-start marker that stays high for as long as the beat is held. It stalls random beats and compares each stalled cycle with the one before, so any drift in data, enables or command fields during a stall shows up. Random pause patterns, including the final-beat position, expose a gap after the last beat, a gap that lasts two cycles, or a beat lost or repeated across a pause. Zero-length commands, single-beat bursts (AND of the masks) and a 255-beat buffer burst that wraps the buffer index cover the boundaries. A second instance with `HOLD_CMD` = 0 shows whether the address is dropped after the first accepted beat.

// File: rtl/burst_wr_pkg.sv
package burst_wr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BEAT   = 2'd1,
        ST_PAUSE  = 2'd2,
        ST_FINISH = 2'd3
    } bw_state_e;

endpackage

// File: rtl/bw_gap_sched.sv
module bw_gap_sched #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] pattern,
    input  logic             advance,
    output logic             pause_req
);
    localparam int PTR_W = (GAP_W > 1) ? $clog2(GAP_W) : 1;

    logic [GAP_W-1:0] pat_q;
    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q <= '0;
            ptr_q <= '0;
        end else if (load) begin
            pat_q <= pattern;
            ptr_q <= '0;
        end else if (advance) begin
            if (ptr_q == PTR_W'(GAP_W - 1)) begin
                ptr_q <= '0;
            end else begin
                ptr_q <= ptr_q + PTR_W'(1);
            end
        end
    end

    always_comb begin
        pause_req = pat_q[ptr_q];
    end

    // R6
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ptr_q) < GAP_W);

endmodule

// File: rtl/bw_fsm.sv
module bw_fsm
    import burst_wr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CNT_W-1:0] cmd_len,
    input  logic             waitreq,
    input  logic             pause_req,
    output logic             take_o,
    output logic             acc_o,
    output logic [CNT_W-1:0] beat_idx_o,
    output logic [CNT_W-1:0] len_o,
    output bw_state_e        state_o,
    output logic             write_o,
    output logic             start_o,
    output logic             done_o,
    output logic             ready_o
);
    bw_state_e        state_q, state_d;
    logic [CNT_W-1:0] beat_q, beat_d;
    logic [CNT_W-1:0] len_q;
    logic             start_q;
    logic             take, acc, last;

    always_comb begin
        take = (state_q == ST_IDLE) && cmd_valid && (cmd_len != '0);
        acc  = (state_q == ST_BEAT) && !waitreq;
        last = (beat_q == len_q - CNT_W'(1));
    end

    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    state_d = ST_BEAT;
                    beat_d  = '0;
                end
            end
            ST_BEAT: begin
                if (acc) begin
                    beat_d = beat_q + CNT_W'(1);
                    if (last) begin
                        state_d = ST_FINISH;
                    end else if (pause_req) begin
                        state_d = ST_PAUSE;
                    end
                end
            end
            ST_PAUSE:  state_d = ST_BEAT;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            len_q   <= '0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            start_q <= take;
            if (take) begin
                len_q <= cmd_len;
            end
        end
    end

    always_comb begin
        take_o     = take;
        acc_o      = acc;
        beat_idx_o = beat_q;
        len_o      = len_q;
        state_o    = state_q;
        write_o    = (state_q == ST_BEAT);
        start_o    = start_q;
        done_o     = (state_q == ST_FINISH);
        ready_o    = (state_q == ST_IDLE);
    end

    // R1
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (state_q == ST_BEAT) && start_q);
    // R4
    beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BEAT) |-> (beat_q < len_q));
    // R6
    pause_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAUSE) |=> (state_q == ST_BEAT));
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/bw_beat_src.sv
module bw_beat_src #(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 8,
    parameter int BUF_DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic                         cmd_src,
    input  logic [DATA_W-1:0]            cmd_seed,
    input  logic [DATA_W/8-1:0]          cmd_be_first,
    input  logic [DATA_W/8-1:0]          cmd_be_last,
    input  logic                         buf_wr_en,
    input  logic [$clog2(BUF_DEPTH)-1:0] buf_wr_idx,
    input  logic [DATA_W-1:0]            buf_wr_data,
    input  logic [CNT_W-1:0]             beat_idx,
    input  logic [CNT_W-1:0]             len,
    input  logic                         active,
    output logic [DATA_W-1:0]            data_o,
    output logic [DATA_W/8-1:0]          be_o
);
    localparam int BE_W  = DATA_W / 8;
    localparam int IDX_W = $clog2(BUF_DEPTH);

    logic [DATA_W-1:0] mem [BUF_DEPTH];
    logic              src_q;
    logic [DATA_W-1:0] seed_q;
    logic [BE_W-1:0]   bef_q, bel_q;
    logic [CNT_W-1:0]  rd_full;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] raw;
    logic              is_first, is_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (buf_wr_en) begin
            mem[buf_wr_idx] <= buf_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= 1'b0;
            seed_q <= '0;
            bef_q  <= '0;
            bel_q  <= '0;
        end else if (load) begin
            src_q  <= cmd_src;
            seed_q <= cmd_seed;
            bef_q  <= cmd_be_first;
            bel_q  <= cmd_be_last;
        end
    end

    always_comb begin
        rd_full  = beat_idx % CNT_W'(BUF_DEPTH);
        rd_idx   = rd_full[IDX_W-1:0];
        raw      = src_q ? mem[rd_idx] : (seed_q + DATA_W'(beat_idx));
        is_first = (beat_idx == '0);
        is_last  = (beat_idx == len - CNT_W'(1));
        data_o   = active ? raw : '0;
        if (!active) begin
            be_o = '0;
        end else if (is_first && is_last) begin
            be_o = bef_q & bel_q;
        end else if (is_first) begin
            be_o = bef_q;
        end else if (is_last) begin
            be_o = bel_q;
        end else begin
            be_o = '1;
        end
    end

endmodule

// File: rtl/burst_wr_engine.sv
module burst_wr_engine
    import burst_wr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 8,
    parameter int GAP_W     = 8,
    parameter int BUF_DEPTH = 8,
    parameter bit HOLD_CMD  = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    output logic                         cmd_ready,
    input  logic [ADDR_W-1:0]            cmd_addr,
    input  logic [CNT_W-1:0]             cmd_len,
    input  logic                         cmd_src,
    input  logic [DATA_W-1:0]            cmd_seed,
    input  logic [GAP_W-1:0]             cmd_gap,
    input  logic [DATA_W/8-1:0]          cmd_be_first,
    input  logic [DATA_W/8-1:0]          cmd_be_last,
    input  logic                         buf_wr_en,
    input  logic [$clog2(BUF_DEPTH)-1:0] buf_wr_idx,
    input  logic [DATA_W-1:0]            buf_wr_data,
    output logic [ADDR_W-1:0]            mm_addr,
    output logic [CNT_W-1:0]             mm_bcount,
    output logic                         mm_write,
    output logic [DATA_W-1:0]            mm_wdata,
    output logic [DATA_W/8-1:0]          mm_be,
    output logic                         mm_burst_start,
    input  logic                         mm_waitreq,
    output logic                         burst_done
);
    logic             take, acc, pause_req;
    logic [CNT_W-1:0] beat_idx, len_q;
    bw_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic             in_burst, show_cmd;

    bw_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_len    (cmd_len),
        .waitreq    (mm_waitreq),
        .pause_req  (pause_req),
        .take_o     (take),
        .acc_o      (acc),
        .beat_idx_o (beat_idx),
        .len_o      (len_q),
        .state_o    (state),
        .write_o    (mm_write),
        .start_o    (mm_burst_start),
        .done_o     (burst_done),
        .ready_o    (cmd_ready)
    );

    bw_gap_sched #(.GAP_W(GAP_W)) gap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .pattern   (cmd_gap),
        .advance   (acc),
        .pause_req (pause_req)
    );

    bw_beat_src #(.DATA_W(DATA_W), .CNT_W(CNT_W), .BUF_DEPTH(BUF_DEPTH)) src_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (take),
        .cmd_src      (cmd_src),
        .cmd_seed     (cmd_seed),
        .cmd_be_first (cmd_be_first),
        .cmd_be_last  (cmd_be_last),
        .buf_wr_en    (buf_wr_en),
        .buf_wr_idx   (buf_wr_idx),
        .buf_wr_data  (buf_wr_data),
        .beat_idx     (beat_idx),
        .len          (len_q),
        .active       (mm_write),
        .data_o       (mm_wdata),
        .be_o         (mm_be)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (take) begin
            addr_q <= cmd_addr;
        end
    end

    always_comb begin
        in_burst = (state == ST_BEAT) || (state == ST_PAUSE);
    end

    generate
        if (HOLD_CMD) begin : g_hold
            always_comb show_cmd = in_burst;
        end else begin : g_first
            always_comb show_cmd = (state == ST_BEAT) && (beat_idx == '0);
        end
    endgenerate

    always_comb begin
        mm_addr   = show_cmd ? addr_q : '0;
        mm_bcount = show_cmd ? len_q  : '0;
    end

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_write && mm_waitreq) |=> (mm_write && $stable(mm_wdata) && $stable(mm_be)
                                      && $stable(mm_addr) && $stable(mm_bcount)));
    // R3
    start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mm_burst_start |=> !mm_burst_start);
    // R3
    start_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mm_burst_start |-> mm_write);
    // R12
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> (!burst_done && cmd_ready));
    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!mm_write && !mm_burst_start && !burst_done && mm_addr == '0));

endmodule

// File: tb/burst_wr_engine_tb_top.sv
`timescale 1ns/1ps
module burst_wr_engine_tb_top;
    localparam int ADDR_W = 32, DATA_W = 32, CNT_W = 8, GAP_W = 8, DEPTH = 8;
    localparam int BE_W = DATA_W / 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0, cmd_src = 0, buf_wr_en = 0, mm_waitreq = 0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [CNT_W-1:0]  cmd_len = '0;
    logic [DATA_W-1:0] cmd_seed = '0, buf_wr_data = '0;
    logic [GAP_W-1:0]  cmd_gap = '0;
    logic [BE_W-1:0]   cmd_be_first = '0, cmd_be_last = '0;
    logic [2:0]        buf_wr_idx = '0;

    logic cmd_ready, mm_write, mm_burst_start, burst_done;
    logic [ADDR_W-1:0] mm_addr;
    logic [CNT_W-1:0]  mm_bcount;
    logic [DATA_W-1:0] mm_wdata;
    logic [BE_W-1:0]   mm_be;
    logic l_ready, l_write, l_start, l_done;
    logic [ADDR_W-1:0] l_addr;
    logic [CNT_W-1:0]  l_bcount;
    logic [DATA_W-1:0] l_wdata;
    logic [BE_W-1:0]   l_be;

    always #4 clk = ~clk;

    burst_wr_engine #(.HOLD_CMD(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_src(cmd_src), .cmd_seed(cmd_seed),
        .cmd_gap(cmd_gap), .cmd_be_first(cmd_be_first), .cmd_be_last(cmd_be_last),
        .buf_wr_en(buf_wr_en), .buf_wr_idx(buf_wr_idx), .buf_wr_data(buf_wr_data),
        .mm_addr(mm_addr), .mm_bcount(mm_bcount), .mm_write(mm_write), .mm_wdata(mm_wdata),
        .mm_be(mm_be), .mm_burst_start(mm_burst_start), .mm_waitreq(mm_waitreq),
        .burst_done(burst_done));

    burst_wr_engine #(.HOLD_CMD(1'b0)) dut_lite_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(l_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_src(cmd_src), .cmd_seed(cmd_seed),
        .cmd_gap(cmd_gap), .cmd_be_first(cmd_be_first), .cmd_be_last(cmd_be_last),
        .buf_wr_en(buf_wr_en), .buf_wr_idx(buf_wr_idx), .buf_wr_data(buf_wr_data),
        .mm_addr(l_addr), .mm_bcount(l_bcount), .mm_write(l_write), .mm_wdata(l_wdata),
        .mm_be(l_be), .mm_burst_start(l_start), .mm_waitreq(mm_waitreq),
        .burst_done(l_done));

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // bench-side copy of the command and buffer
    logic [DATA_W-1:0] ref_buf [DEPTH];
    logic [ADDR_W-1:0] e_addr;
    int                e_len;
    logic              e_src;
    logic [DATA_W-1:0] e_seed;
    logic [GAP_W-1:0]  e_gap;
    logic [BE_W-1:0]   e_bef, e_bel;

    function automatic logic [DATA_W-1:0] f_data(int k);
        if (e_src) return ref_buf[k % DEPTH];
        return e_seed + DATA_W'(k);
    endfunction

    function automatic logic [BE_W-1:0] f_be(int k);
        if (e_len == 1) return e_bef & e_bel;
        if (k == 0) return e_bef;
        if (k == e_len - 1) return e_bel;
        return '1;
    endfunction

    // monitor state
    bit mon_on = 0, in_burst = 0, prev_start = 0, prev_stall = 0;
    bit prev_acc_mid = 0, prev_acc_last = 0, prev_pause = 0, prev_done = 0;
    int acc_cnt = 0, starts = 0, dones = 0, prev_k = 0, force_stall = 0, stall_pct = 0;
    logic [DATA_W-1:0] p_data;
    logic [BE_W-1:0]   p_be;
    logic [ADDR_W-1:0] p_addr;

    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            bit nw;
            if (in_burst) chk(!cmd_ready, "R1", "ready during burst", cmd_ready, 0);
            if (prev_done) chk(cmd_ready, "R12", "ready after done", cmd_ready, 1);
            if (cmd_ready) begin
                chk(!mm_write && !mm_burst_start && !burst_done, "R13", "idle strobes",
                    {mm_write, mm_burst_start, burst_done}, 0);
                chk(mm_addr == 0 && mm_bcount == 0, "R13", "idle addr/count", mm_addr, 0);
            end
            if (mm_burst_start) begin
                chk(!prev_start, "R3", "start repeated", 1, 0);
                chk(mm_write && acc_cnt == 0, "R3", "start on first beat", mm_write, 1);
                starts++;
                in_burst = 1;
            end else if (mm_write && acc_cnt == 0 && !prev_stall) begin
                chk(0, "R3", "first beat without start", 0, 1);
            end
            if (prev_acc_mid) begin
                chk(mm_write == !e_gap[prev_k % GAP_W], "R6", "gap decision", mm_write,
                    !e_gap[prev_k % GAP_W]);
            end
            if (prev_pause) chk(mm_write, "R6", "pause lasts one cycle", mm_write, 1);
            if (in_burst && !mm_write && !burst_done) begin
                chk(mm_addr == e_addr && int'(mm_bcount) == e_len, "R10",
                    "hold during pause", mm_addr, e_addr);
                chk(l_addr == 0 && l_bcount == 0, "R11", "lite zero in pause", l_addr, 0);
            end
            if (mm_write) begin
                if (prev_stall) begin
                    chk(mm_wdata == p_data && mm_be == p_be && mm_addr == p_addr, "R5",
                        "held under stall", mm_wdata, p_data);
                end
                chk(acc_cnt < e_len, "R4", "beat count bound", acc_cnt, e_len);
                chk(mm_wdata == f_data(acc_cnt), e_src ? "R8" : "R7", "beat data",
                    mm_wdata, f_data(acc_cnt));
                chk(mm_be == f_be(acc_cnt), "R9", "byte enables", mm_be, f_be(acc_cnt));
                chk(mm_addr == e_addr && int'(mm_bcount) == e_len, "R10", "held cmd",
                    mm_addr, e_addr);
                if (acc_cnt == 0)
                    chk(l_addr == e_addr && int'(l_bcount) == e_len, "R11", "lite first",
                        l_addr, e_addr);
                else
                    chk(l_addr == 0 && l_bcount == 0, "R11", "lite later", l_addr, 0);
            end
            if (burst_done) begin
                chk(prev_acc_last && acc_cnt == e_len, "R12", "done timing/beats",
                    acc_cnt, e_len);
                dones++;
                in_burst = 0;
            end
            // drive the stall for the coming edge
            if (force_stall > 0) begin
                nw = 1;
                force_stall--;
            end else begin
                nw = ($urandom % 100) < stall_pct;
            end
            mm_waitreq <= nw;
            prev_start    = mm_burst_start;
            prev_done     = burst_done;
            prev_stall    = mm_write && nw;
            prev_pause    = in_burst && !mm_write && !burst_done;
            prev_acc_mid  = mm_write && !nw && (acc_cnt + 1 < e_len);
            prev_acc_last = mm_write && !nw && (acc_cnt + 1 == e_len);
            prev_k  = acc_cnt;
            p_data  = mm_wdata;
            p_be    = mm_be;
            p_addr  = mm_addr;
            if (mm_write && !nw) acc_cnt++;
        end
    end

    task automatic load_buf(input int idx, input logic [DATA_W-1:0] d);
        @(negedge clk);
        buf_wr_en = 1; buf_wr_idx = 3'(idx); buf_wr_data = d;
        ref_buf[idx] = d;
        @(negedge clk);
        buf_wr_en = 0;
    endtask

    task automatic run_burst(input logic [ADDR_W-1:0] a, input int len, input logic src,
                             input logic [DATA_W-1:0] seed, input logic [GAP_W-1:0] gap,
                             input logic [BE_W-1:0] bf, input logic [BE_W-1:0] bl,
                             input int fstall, input int pct);
        int d0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        e_addr = a; e_len = len; e_src = src; e_seed = seed; e_gap = gap;
        e_bef = bf; e_bel = bl; acc_cnt = 0; stall_pct = pct;
        force_stall = fstall;
        cmd_valid = 1; cmd_addr = a; cmd_len = CNT_W'(len); cmd_src = src;
        cmd_seed = seed; cmd_gap = gap; cmd_be_first = bf; cmd_be_last = bl;
        d0 = dones;
        @(negedge clk);
        cmd_valid = 0;
        while (dones == d0) @(negedge clk);
        chk(acc_cnt == len, "R4", "beats per burst", acc_cnt, len);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_buf[i] = '0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(cmd_ready && !mm_write && !burst_done && !mm_burst_start, "R13", "reset state",
            {cmd_ready, mm_write, burst_done, mm_burst_start}, 4'b1000);
        mon_on = 1;
        for (int i = 0; i < DEPTH; i++) load_buf(i, 32'hA500_0000 + 32'(i * 17));

        // zero-length command is ignored
        begin
            int s0 = starts;
            @(negedge clk);
            cmd_valid = 1; cmd_len = 0; cmd_addr = 32'h100;
            repeat (3) @(negedge clk);
            cmd_valid = 0;
            @(negedge clk);
            chk(cmd_ready && starts == s0 && !mm_write, "R2", "zero length ignored",
                starts, s0);
        end
        // first cycle stalled: start must still drop
        run_burst(32'h1000, 4, 0, 32'hFFFF_FFFE, 8'h00, 4'b1100, 4'b0011, 3, 0);
        // single beat, AND of masks
        run_burst(32'h2000, 1, 1, 0, 8'hFF, 4'b1110, 4'b0111, 0, 0);
        // every gap bit set
        run_burst(32'h3000, 10, 1, 0, 8'hFF, 4'b0001, 4'b1000, 0, 20);
        // long buffer burst wraps the buffer index
        run_burst(32'h4000, 255, 1, 0, 8'h81, 4'b1111, 4'b0101, 0, 25);
        for (int n = 0; n < 40; n++) begin
            run_burst($urandom, 1 + ($urandom % 20), 1'($urandom), $urandom,
                      8'($urandom), 4'($urandom), 4'($urandom), $urandom % 3, $urandom % 60);
            if (n % 10 == 5) load_buf($urandom % DEPTH, $urandom);
        end
        repeat (4) @(negedge clk);
        chk(starts == dones, "R3", "one start per burst", starts, dones);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog R4 actual=hung expected=complete");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule